// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block picks the divider settings of a pixel-clock PLL. After a one-cycle start pulse it takes a requested output frequency in kHz and walks through every allowed combination of post-divider P, reference divider M and feedback divider N. For each combination it computes the frequency the PLL would make from a fixed 33333 kHz reference, using integer division. It keeps the combination whose frequency lies closest to the request. When the walk is over it presents the winning P, M and N together with three packed register bytes, and raises a one-cycle done pulse.

A post-divider value is tried only when the target multiplied by P lands inside the oscillator window of 400000 to 800000 kHz, both ends included. Every candidate frequency comes from a shared restoring divider that produces one quotient bit per clock. The engine waits for that divider before it judges each candidate, so a full search takes many thousands of cycles. The search bounds are parameters, so a smaller search space can be used for quick runs.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, `m_out`, `n_out` and `p_out` are zero and `done` is low.
- R2: Post-divider candidates are visited in the order 16, 8, 4, 2, 1. A value P is searched only if 400000 <= target*P <= 800000 (kHz). Otherwise it is skipped.
- R3: For each accepted P, M steps from M_MIN to M_MAX (default 1..32) in the outer loop. For each M, N steps from N_MIN to N_MAX (default 17..256) in the inner loop.
- R4: The frequency of a candidate is floor(33333*N / (M*P)) in kHz.
- R5: The result minimises |candidate - target|. The stored best is replaced only on a strictly smaller error, so among equal errors the first one visited wins.
- R6: If no post-divider passes the window test, `m_out`, `n_out` and `p_out` are all zero when done rises.
- R7: `m_byte` holds M-1 in bits 6:0 and bit 8 of N-1 in bit 7.
- R8: `n_byte` holds bits 7:0 of N-1.
- R9: `p_byte` holds P-1 in bits 2:0 and a spread-select bit at bit 3, which is always 0. Bits 7:4 are 0.
- R10: `target_khz` is sampled only on a start accepted while idle. A start pulse during a running search is ignored and does not change its result.
- R11: `done` is high for exactly one cycle per search. The result outputs change only in the cycle where `done` is high and hold their values until the next completion.
- R12: Each quotient comes from a restoring divider that retires one quotient bit per clock. Its final quotient and remainder satisfy q*d + r = n with r < d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a search |
| target_khz | input | 17 | Requested frequency in kHz, sampled on an accepted start |
| m_out | output | 6 | Chosen reference divider M |
| n_out | output | 9 | Chosen feedback divider N |
| p_out | output | 5 | Chosen post-divider P |
| m_byte | output | 8 | Packed M register byte |
| n_byte | output | 8 | Packed N register byte |
| p_byte | output | 8 | Packed P register byte |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench drives targets whose oscillator products fall exactly on 400000 and 800000, and targets one kHz on either side of those values. A design with an off-by-one window test would skip a post-divider it should search, or search one it should skip, and then pick a different P. The reduced search space contains divider ratios that repeat, such as N=34/M=2 against N=17/M=1, so errors tie often. A design that replaced the best on equal error would report a later M or N. Targets with no valid post-divider must produce all-zero results. A second start issued in the middle of a search must leave the result tied to the first target. The outputs are also checked to hold still after done falls.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK_P,
        ST_LAUNCH,
        ST_WAIT,
        ST_FINISH
    } search_state_e;

endpackage

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W:0]       rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     den;
        logic [W-1:0]     num;
    } div_st_t;

    div_st_t d, q;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem[W-1:0], q.quo[W-1]};
        trial   = shifted - {1'b0, q.den};
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(W);
            d.rem  = '0;
            d.quo  = num;
            d.den  = den;
            d.num  = num;
        end else if (q.busy) begin
            if (!trial[W]) begin
                d.rem = trial;
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = shifted;
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.quo;

    // R12: the finished quotient and remainder reconstruct the dividend
    a_r12_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ((2*W)'(q.quo) * (2*W)'(q.den) + (2*W)'(q.rem[W-1:0]) == (2*W)'(q.num)));

    // R12: the remainder stays below the divisor
    a_r12_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.rem[W-1:0] < q.den));

    // R12: one bit per cycle, so a new operation never arrives while busy
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

endmodule

// File: rtl/pll_err_cmp.sv
module pll_err_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cand,
    input  logic [W-1:0] target,
    input  logic [W-1:0] best,
    output logic [W-1:0] err,
    output logic         better
);
    always_comb begin
        if (cand > target) err = cand - target;
        else               err = target - cand;
        better = (err < best);
    end
endmodule

// File: rtl/pll_reg_pack.sv
module pll_reg_pack #(
    parameter int unsigned M_W = 6,
    parameter int unsigned N_W = 9,
    parameter int unsigned P_W = 5
) (
    input  logic [M_W-1:0] m_val,
    input  logic [N_W-1:0] n_val,
    input  logic [P_W-1:0] p_val,
    output logic [7:0]     m_byte,
    output logic [7:0]     n_byte,
    output logic [7:0]     p_byte
);
    logic [M_W-1:0] mm1;
    logic [N_W-1:0] nm1;
    logic [P_W-1:0] pm1;
    logic           n_hi;
    logic           unused_pack;

    assign mm1 = m_val - 1'b1;
    assign nm1 = n_val - 1'b1;
    assign pm1 = p_val - 1'b1;

    generate
        if (N_W > 8) begin : g_nhi
            assign n_hi = nm1[8];
        end else begin : g_nlo
            assign n_hi = 1'b0;
        end
    endgenerate

    assign m_byte = {n_hi, 7'(mm1)};
    assign n_byte = nm1[7:0];
    assign p_byte = {4'b0000, 1'b0, pm1[2:0]};

    assign unused_pack = ^{nm1, pm1};
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
    import pll_search_pkg::*;
#(
    parameter int unsigned TGT_W   = 17,
    parameter int unsigned M_W     = 6,
    parameter int unsigned N_W     = 9,
    parameter int unsigned P_W     = 5,
    parameter int unsigned DIV_W   = 32,
    parameter int unsigned REF_KHZ = 33333,
    parameter int unsigned VCO_MIN = 400000,
    parameter int unsigned VCO_MAX = 800000,
    parameter int unsigned P_TOP   = 16,
    parameter int unsigned P_STEPS = 5,
    parameter int unsigned M_MIN   = 1,
    parameter int unsigned M_MAX   = 32,
    parameter int unsigned N_MIN   = 17,
    parameter int unsigned N_MAX   = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TGT_W-1:0] target_khz,
    output logic [M_W-1:0]   m_out,
    output logic [N_W-1:0]   n_out,
    output logic [P_W-1:0]   p_out,
    output logic [7:0]       m_byte,
    output logic [7:0]       n_byte,
    output logic [7:0]       p_byte,
    output logic             done
);
    localparam int unsigned PI_W = $clog2(P_STEPS);
    localparam int unsigned VP_W = TGT_W + P_W;
    localparam logic [VP_W-1:0] VCO_LO = VP_W'(VCO_MIN);
    localparam logic [VP_W-1:0] VCO_HI = VP_W'(VCO_MAX);
    localparam logic [PI_W-1:0] P_LAST = PI_W'(P_STEPS - 1);

    typedef struct packed {
        search_state_e    st;
        logic [PI_W-1:0]  p_idx;
        logic [M_W-1:0]   m;
        logic [N_W-1:0]   n;
        logic [TGT_W-1:0] tgt;
        logic [DIV_W-1:0] best_err;
        logic [M_W-1:0]   best_m;
        logic [N_W-1:0]   best_n;
        logic [P_W-1:0]   best_p;
        logic [M_W-1:0]   out_m;
        logic [N_W-1:0]   out_n;
        logic [P_W-1:0]   out_p;
        logic             done;
    } srch_st_t;

    localparam srch_st_t RESET_VAL = '{st: ST_IDLE, default: '0};

    srch_st_t d, q;

    logic [P_W-1:0]   p_cur;
    logic [VP_W-1:0]  vco;
    logic             p_ok;
    logic             div_start;
    logic [DIV_W-1:0] div_num;
    logic [DIV_W-1:0] div_den;
    logic             div_done;
    logic [DIV_W-1:0] div_quo;
    logic [DIV_W-1:0] cur_err;
    logic             cur_better;
    logic             last_n;
    logic             last_m;

    assign p_cur     = P_W'(P_TOP >> q.p_idx);
    assign vco       = VP_W'(q.tgt) * VP_W'(p_cur);
    assign p_ok      = (vco >= VCO_LO) && (vco <= VCO_HI);
    assign div_start = (q.st == ST_LAUNCH);
    assign div_num   = DIV_W'(REF_KHZ) * DIV_W'(q.n);
    assign div_den   = DIV_W'(q.m) * DIV_W'(p_cur);
    assign last_n    = (q.n == N_W'(N_MAX));
    assign last_m    = (q.m == M_W'(M_MAX));

    pll_restoring_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    pll_err_cmp #(.W(DIV_W)) u_cmp (
        .cand   (div_quo),
        .target (DIV_W'(q.tgt)),
        .best   (q.best_err),
        .err    (cur_err),
        .better (cur_better)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.tgt      = target_khz;
                    d.p_idx    = '0;
                    d.best_err = '1;
                    d.best_m   = '0;
                    d.best_n   = '0;
                    d.best_p   = '0;
                    d.st       = ST_PICK_P;
                end
            end
            ST_PICK_P: begin
                if (p_ok) begin
                    d.m  = M_W'(M_MIN);
                    d.n  = N_W'(N_MIN);
                    d.st = ST_LAUNCH;
                end else if (q.p_idx == P_LAST) begin
                    d.st = ST_FINISH;
                end else begin
                    d.p_idx = q.p_idx + 1'b1;
                end
            end
            ST_LAUNCH: begin
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_done) begin
                    if (cur_better) begin
                        d.best_err = cur_err;
                        d.best_m   = q.m;
                        d.best_n   = q.n;
                        d.best_p   = p_cur;
                    end
                    if (!last_n) begin
                        d.n  = q.n + 1'b1;
                        d.st = ST_LAUNCH;
                    end else if (!last_m) begin
                        d.m  = q.m + 1'b1;
                        d.n  = N_W'(N_MIN);
                        d.st = ST_LAUNCH;
                    end else if (q.p_idx == P_LAST) begin
                        d.st = ST_FINISH;
                    end else begin
                        d.p_idx = q.p_idx + 1'b1;
                        d.st    = ST_PICK_P;
                    end
                end
            end
            ST_FINISH: begin
                d.out_m = q.best_m;
                d.out_n = q.best_n;
                d.out_p = q.best_p;
                d.done  = 1'b1;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    pll_reg_pack #(.M_W(M_W), .N_W(N_W), .P_W(P_W)) u_pack (
        .m_val  (q.out_m),
        .n_val  (q.out_n),
        .p_val  (q.out_p),
        .m_byte (m_byte),
        .n_byte (n_byte),
        .p_byte (p_byte)
    );

    assign m_out = q.out_m;
    assign n_out = q.out_n;
    assign p_out = q.out_p;
    assign done  = q.done;

    // R2: a division is launched only for a post-divider inside the VCO window
    a_r2_vco_window: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LAUNCH) |-> (vco >= VCO_LO && vco <= VCO_HI));

    // R3: launched candidates stay inside the configured M and N ranges
    a_r3_mn_range: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LAUNCH) |-> (q.m >= M_W'(M_MIN) && q.m <= M_W'(M_MAX) &&
                                 q.n >= N_W'(N_MIN) && q.n <= N_W'(N_MAX)));

    // R5: during a search the best error never grows
    a_r5_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> (q.best_err <= $past(q.best_err)));

    // R6: an empty result is all zeros
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.out_p == '0) |-> (q.out_m == '0 && q.out_n == '0));

    // R10: the sampled target holds while a search runs
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.tgt));

    // R11: done lasts a single cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R11: results move only together with done
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> ($stable(q.out_m) && $stable(q.out_n) && $stable(q.out_p)));

endmodule

// File: tb/pll_coef_search_bench.sv
module pll_coef_search_bench;

    localparam int unsigned B_M_MAX = 3;
    localparam int unsigned B_N_MIN = 17;
    localparam int unsigned B_N_MAX = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [16:0] target_khz = '0;
    logic [5:0]  m_out;
    logic [8:0]  n_out;
    logic [4:0]  p_out;
    logic [7:0]  m_byte, n_byte, p_byte;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    typedef struct {
        int m;
        int n;
        int p;
        int tgt;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;
    int   results_seen = 0;

    always #2 clk = ~clk;

    pll_coef_search #(
        .M_MAX(B_M_MAX),
        .N_MIN(B_N_MIN),
        .N_MAX(B_N_MAX)
    ) u_pll_coef_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .target_khz (target_khz),
        .m_out      (m_out),
        .n_out      (n_out),
        .p_out      (p_out),
        .m_byte     (m_byte),
        .n_byte     (n_byte),
        .p_byte     (p_byte),
        .done       (done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model built from R2..R5
    function automatic exp_t model(input int t);
        exp_t   r;
        longint best;
        longint c, e;
        int     pl[5];
        pl = '{16, 8, 4, 2, 1};
        r = '{m: 0, n: 0, p: 0, tgt: t};
        best = 64'h0FFFFFFFF;
        foreach (pl[i]) begin
            longint vp;
            vp = longint'(t) * pl[i];
            if (vp > 800000 || vp < 400000) continue;
            for (int m = 1; m <= int'(B_M_MAX); m++) begin
                for (int n = int'(B_N_MIN); n <= int'(B_N_MAX); n++) begin
                    c = (longint'(33333) * n) / (m * pl[i]);
                    e = (c > t) ? c - t : t - c;
                    if (e < best) begin
                        best = e;
                        r.m = m;
                        r.n = n;
                        r.p = pl[i];
                    end
                end
            end
        end
        return r;
    endfunction

    // Driver: push the expected result, then pulse start
    task automatic run_search(input int t, input bit inject_busy_start);
        exp_q.push_back(model(t));
        @(negedge clk);
        start = 1'b1;
        target_khz = 17'(t);
        @(negedge clk);
        start = 1'b0;
        target_khz = 17'(t ^ 17'h0ABCD);
        if (inject_busy_start) begin
            repeat (60) @(negedge clk);
            // R10: a second start mid-search must be ignored
            start = 1'b1;
            target_khz = 17'd33333;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop and compare when done is seen
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done && done) check("R11 done longer than one cycle", 1, 0);
            if (done) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check("R11 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    last_exp = e;
                    results_seen++;
                    check("R2 post-divider", p_out, e.p);
                    check("R3 reference divider", m_out, e.m);
                    check("R4 R5 feedback divider", n_out, e.n);
                    if (e.p != 0) begin
                        check("R7 m_byte", m_byte, (((e.n - 1) >> 8) & 1) << 7 | ((e.m - 1) & 8'h7F));
                        check("R8 n_byte", n_byte, (e.n - 1) & 8'hFF);
                        check("R9 p_byte", p_byte, (e.p - 1) & 7);
                    end else begin
                        check("R6 empty result m", m_out, 0);
                        check("R6 empty result n", n_out, 0);
                    end
                end
            end
            prev_done = done;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 m_out at reset", m_out, 0);
        check("R1 n_out at reset", n_out, 0);
        check("R1 p_out at reset", p_out, 0);
        check("R1 done at reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 done idle after reset", done, 0);

        run_search(25000, 1'b0);   // P=16 at the 400000 edge only
        run_search(50000, 1'b0);   // P=16 at 800000 and P=8 at 400000
        run_search(50001, 1'b0);   // P=16 just above the window
        run_search(49999, 1'b0);   // P=8 just below the window
        run_search(24999, 1'b0);   // R6: nothing accepted
        run_search(131071, 1'b0);  // largest target, P=4
        run_search(100000, 1'b0);  // P=8 and P=4 both accepted
        run_search(1000, 1'b0);    // R6: far below the window
        run_search(40000, 1'b1);   // R10: busy start ignored
        check("R10 target sampled on start", last_exp.tgt, 40000);

        // R11: outputs hold after done
        begin
            logic [5:0] hm;
            logic [8:0] hn;
            logic [4:0] hp;
            hm = m_out; hn = n_out; hp = p_out;
            repeat (20) @(negedge clk);
            check("R11 m_out held", m_out, hm);
            check("R11 n_out held", n_out, hn);
            check("R11 p_out held", p_out, hp);
            check("R11 done low while idle", done, 0);
        end
        // R12 is exercised through every divider result compared above
        check("R11 all results seen", results_seen, 9);
        check("R11 queue drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule